// File: doc/BRIEF.md
# Bit-centre sample enable generator

This block recovers bit timing from a serial line that runs at 12 Mbit/s. The line is driven from a remote clock that has no relation to the local 90 MHz clock. One bit therefore spans 7.5 local clock cycles. The block emits a one-cycle strobe close to the middle of every bit, together with the value of the line at that point. Downstream logic in the 90 MHz domain can then consume the serial stream with no separate oversampling clock and no clock-domain FIFO.

The line first passes through a two-flop synchroniser. A change detector watches the synchronised line. Phase is kept in half-cycle units, with fifteen steps per bit and two steps per clock. Each line change reloads the phase, which pulls the strobe back toward the middle of the bit. Between changes the phase counter free-runs. The strobe fires when the counter steps across the mid-bit threshold, so the spacing between strobes falls out as 8 and 7 cycles in turn.

Top module: `bit_centre_sampler`

## Requirements
- R1: After reset, while the line has not changed, `sample_en` stays low.
- R2: While `rst_n` is low, and in the first cycle after it is released, `sample_en` and `sample_data` are both 0.
- R3: When the line changes between two rising edges, `sample_en` is first high after the 6th rising edge that follows the change, and low after the 1st to 5th.
- R4: `sample_en` is never high in two consecutive cycles.
- R5: While the line is constant, successive strobes are spaced 8, 7, 8, 7 ... cycles apart, starting with 8 after the first strobe that follows a change. Two strobes in a row are never spaced equally.
- R6: `sample_data` only changes in a cycle where `sample_en` is high, and it then holds the synchronised line value.
- R7: A line change reloads the phase whatever the free-running phase was. The next strobe follows R3 timing and is not placed where the free-running schedule would have put it.
- R8: For a 12 Mbit/s stream whose rate is off by ±0.1%, with runs of up to 20 equal bits, these hold: every bit produces exactly one strobe, `sample_data` equals that bit, and the instant the line is sampled lies within ±1 clock of the bit centre. The sampled instant is two clocks before the edge that raises `sample_en`.
- R9: Asserting `rst_n` during operation clears the tracking at once. After release, no strobe appears until the next line change, and that change then behaves as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock (nominally 7.5 times the bit rate) |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released in step with `clk` |
| line_in | input | 1 | Asynchronous serial data line |
| sample_en | output | 1 | One-cycle strobe near the centre of each bit |
| sample_data | output | 1 | Line value captured with the last strobe |

## Verification
The assertions take it for granted that the line only changes at bit boundaries of a stream close to the nominal rate. They also take it that changes come far enough apart that one never lands inside the three cycles after the phase reload. In addition, the interval checks assume that no change ever falls in the same cycle as a strobe. The stimulus keeps to this in two ways. Directed changes are applied at the falling clock edge, at least several bit times apart. The stream cases place boundaries at fractional nanosecond offsets from the clock, with a rate error of only 0.1% and equal-bit runs capped at 20. Under those conditions the drift during a run stays well under a quarter of a clock.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Tracker state: waiting for a first line change, or following one.
  typedef enum logic {
    TRK_IDLE   = 1'b0,
    TRK_LOCKED = 1'b1
  } trk_state_e;

  // Defaults: 15 half-cycles per bit (7.5 clocks), 2 half-cycles per clock.
  localparam int unsigned DEF_BIT_HALF_CYCLES = 15;
  localparam int unsigned DEF_STEP            = 2;
  localparam int unsigned DEF_SYNC_STAGES     = 2;

endpackage

// File: rtl/bcs_line_sync.sv
module bcs_line_sync #(
  parameter int unsigned STAGES = bcs_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_sync
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic stage_d;
      if (g == 0) begin : g_first
        always_comb stage_d = line_in;
      end else begin : g_next
        always_comb stage_d = chain_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= stage_d;
      end
    end
  endgenerate

  assign line_sync = chain_q[STAGES-1];

endmodule

// File: rtl/bcs_change_det.sv
module bcs_change_det (
  input  logic clk,
  input  logic rst_n,
  input  logic line_sync,
  output logic edge_seen
);
  timeunit 1ns;
  timeprecision 1ps;

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= line_sync;
  end

  // Either polarity of change re-centres the tracker.
  assign edge_seen = line_sync ^ prev_q;

endmodule

// File: rtl/bcs_phase_track.sv
module bcs_phase_track
  import bcs_pkg::*;
#(
  parameter int unsigned BIT_HALF_CYCLES = DEF_BIT_HALF_CYCLES,
  parameter int unsigned STEP            = DEF_STEP
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_seen,
  input  logic line_sync,
  output logic sample_en,
  output logic sample_data
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned PH_W  = $clog2(BIT_HALF_CYCLES);
  localparam int unsigned SUM_W = PH_W + 1;
  localparam logic [SUM_W-1:0] MOD_V  = SUM_W'(BIT_HALF_CYCLES);
  localparam logic [SUM_W-1:0] STEP_V = SUM_W'(STEP);
  // First half-cycle position at or past mid-bit.
  localparam logic [SUM_W-1:0] THR_V  = SUM_W'((BIT_HALF_CYCLES + 1) / 2);
  // The reload lands one clock after the synchronised line changed.
  localparam logic [PH_W-1:0]  RELOAD_V = PH_W'(STEP);

  trk_state_e        trk_q, trk_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic              ph_ce;
  logic              fire;
  logic              en_q;
  logic              data_q;
  logic [SUM_W-1:0]  ph_ext, ph_sum;
  logic [PH_W-1:0]   ph_wrap;
  logic              cross_mid;

  // Next-state logic
  always_comb begin
    ph_ext    = {1'b0, ph_q};
    ph_sum    = ph_ext + STEP_V;
    ph_wrap   = (ph_sum >= MOD_V) ? PH_W'(ph_sum - MOD_V) : PH_W'(ph_sum);
    cross_mid = (ph_ext < THR_V) && (ph_sum >= THR_V);

    trk_d = trk_q;
    ph_d  = ph_q;
    ph_ce = 1'b0;
    fire  = 1'b0;

    if (edge_seen) begin
      trk_d = TRK_LOCKED;
      ph_d  = RELOAD_V;
      ph_ce = 1'b1;
    end else if (trk_q == TRK_LOCKED) begin
      ph_d  = ph_wrap;
      ph_ce = 1'b1;
      fire  = cross_mid;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_q  <= TRK_IDLE;
      ph_q   <= '0;
      en_q   <= 1'b0;
      data_q <= 1'b0;
    end else begin
      trk_q <= trk_d;
      if (ph_ce) ph_q <= ph_d;
      en_q <= fire;
      if (fire) data_q <= line_sync;
    end
  end

  assign sample_en   = en_q;
  assign sample_data = data_q;

endmodule

// File: rtl/bit_centre_sampler.sv
module bit_centre_sampler
  import bcs_pkg::*;
#(
  parameter int unsigned BIT_HALF_CYCLES = DEF_BIT_HALF_CYCLES,
  parameter int unsigned STEP            = DEF_STEP,
  parameter int unsigned SYNC_STAGES     = DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic sample_en,
  output logic sample_data
);
  timeunit 1ns;
  timeprecision 1ps;

  logic line_sync;
  logic edge_seen;

  bcs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (line_in),
    .line_sync (line_sync)
  );

  bcs_change_det u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_sync (line_sync),
    .edge_seen (edge_seen)
  );

  bcs_phase_track #(
    .BIT_HALF_CYCLES (BIT_HALF_CYCLES),
    .STEP            (STEP)
  ) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .edge_seen   (edge_seen),
    .line_sync   (line_sync),
    .sample_en   (sample_en),
    .sample_data (sample_data)
  );

endmodule

// File: rtl/bit_centre_sampler_chk.sv
module bit_centre_sampler_chk #(
  parameter int unsigned BIT_HALF_CYCLES = bcs_pkg::DEF_BIT_HALF_CYCLES
) (
  input logic clk,
  input logic rst_n,
  input logic edge_seen,
  input logic sample_en,
  input logic sample_data
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned GAP_LO = BIT_HALF_CYCLES / 2;
  localparam int unsigned GAP_HI = (BIT_HALF_CYCLES + 1) / 2;
  localparam int unsigned GAP_W  = $clog2(GAP_HI + 2) + 1;

  logic             seen_q;
  logic             had_en_q;
  logic             clean_q;
  logic             prev_clean_q;
  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] last_gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q       <= 1'b0;
      had_en_q     <= 1'b0;
      clean_q      <= 1'b0;
      prev_clean_q <= 1'b0;
      gap_q        <= '0;
      last_gap_q   <= '0;
    end else begin
      seen_q <= seen_q | edge_seen;
      if (sample_en) begin
        had_en_q     <= 1'b1;
        gap_q        <= GAP_W'(1);
        clean_q      <= 1'b1;
        last_gap_q   <= gap_q;
        prev_clean_q <= clean_q & had_en_q;
      end else begin
        if (gap_q != '1) gap_q <= gap_q + GAP_W'(1);
        if (edge_seen)   clean_q <= 1'b0;
      end
    end
  end

  // R1 R9
  no_early_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !sample_en);

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> !sample_en);

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |-> $stable(sample_data));

  // R3
  reload_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> !sample_en);

  // R3 R7
  reload_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(edge_seen, 3) && !$past(edge_seen, 2) && !$past(edge_seen, 1) && !edge_seen)
      |=> sample_en);

  // R5
  gap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && had_en_q && clean_q)
      |-> (gap_q == GAP_W'(GAP_LO) || gap_q == GAP_W'(GAP_HI)));

  generate
    if (GAP_LO != GAP_HI) begin : g_alt
      // R5
      gap_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && had_en_q && clean_q && prev_clean_q) |-> (gap_q != last_gap_q));
    end
  endgenerate

endmodule

bind bit_centre_sampler bit_centre_sampler_chk #(
  .BIT_HALF_CYCLES (BIT_HALF_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .edge_seen   (edge_seen),
  .sample_en   (sample_en),
  .sample_data (sample_data)
);

// File: tb/bit_centre_sampler_bench.sv
module bit_centre_sampler_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam real TCLK    = 4.0;
  localparam int  NBITS   = 32;
  localparam int  WD_CYC  = 100000;

  typedef struct packed {
    logic [31:0] bits;     // stimulus, bit 0 sent first
    logic [15:0] per_ps;   // bit period in ps (7.5 clocks +/- 0.1%)
    logic [7:0]  exp_cnt;  // strobes expected inside the stream
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{32'h5555_5555, 16'd30030, 8'd32},
    '{32'h0F0F_F0F1, 16'd30030, 8'd32},
    '{32'h000F_FFF1, 16'd30030, 8'd32},
    '{32'hFFFF_F001, 16'd30030, 8'd32},
    '{32'h000F_FFF1, 16'd29970, 8'd32},
    '{32'hFFFF_F001, 16'd29970, 8'd32},
    '{32'h5555_5555, 16'd29970, 8'd32}
  };

  logic clk;
  logic rst_n;
  logic line_in;
  logic sample_en;
  logic sample_data;

  bit_centre_sampler u_bit_centre_sampler (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_in     (line_in),
    .sample_en   (sample_en),
    .sample_data (sample_data)
  );

  int  n_chk;
  int  n_pass;
  bit  finished;

  // Stream model shared with the monitor
  bit      mon_on;
  realtime t0, t_end, tb, last_pos;
  realtime sb [NBITS];
  logic    sv [NBITS];
  int      next_idx;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (ok) n_pass++;
    else $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_pass, n_chk);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) last_pos = $realtime;

  // Stream monitor: one strobe per bit, right value, near the centre (R8).
  always @(negedge clk) begin
    if (mon_on && sample_en) begin
      realtime st, err;
      int idx;
      st = last_pos - 2.0 * TCLK;
      if (st < t0) begin
        chk(1'b0, "R1", "strobe before first change", 1, 0);
      end else if (st < t_end) begin
        idx = 0;
        for (int i = 0; i < NBITS; i++) if (sb[i] <= st) idx = i;
        chk(idx == next_idx, "R8", "bit index of strobe", idx, next_idx);
        chk(sample_data == sv[idx], "R8", "captured bit value", sample_data, sv[idx]);
        err = st - (sb[idx] + tb / 2.0);
        if (err < 0.0) err = -err;
        chk(err <= TCLK, "R8", "centre error ps", longint'(err * 1000.0), 4000);
        next_idx = idx + 1;
      end
    end
  end

  task automatic run_stream(input vec_t v);
    do_reset();
    line_in = 1'b0;
    repeat (5) @(negedge clk);
    tb = real'(v.per_ps) / 1000.0;
    t0 = $realtime + 1.3;
    for (int i = 0; i < NBITS; i++) begin
      sb[i] = t0 + real'(i) * tb;
      sv[i] = v.bits[i];
    end
    t_end    = t0 + real'(NBITS) * tb;
    next_idx = 0;
    mon_on   = 1'b1;
    for (int i = 0; i < NBITS; i++) begin
      #(sb[i] - $realtime);
      line_in = sv[i];
    end
    #(t_end - $realtime + 20.0);
    mon_on = 1'b0;
    chk(next_idx == int'(v.exp_cnt), "R8", "strobes in stream", next_idx, v.exp_cnt);
  endtask

  initial begin
    n_chk    = 0;
    n_pass   = 0;
    finished = 1'b0;
    mon_on   = 1'b0;
    rst_n    = 1'b0;
    line_in  = 1'b0;
    t0 = 0.0; t_end = 0.0; tb = 30.0; last_pos = 0.0; next_idx = 0;

    // R2: reset state
    @(negedge clk);
    chk(sample_en == 1'b0, "R2", "sample_en in reset", sample_en, 0);
    chk(sample_data == 1'b0, "R2", "sample_data in reset", sample_data, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sample_en == 1'b0, "R2", "sample_en after release", sample_en, 0);
    chk(sample_data == 1'b0, "R2", "sample_data after release", sample_data, 0);

    // Vector table: offset-rate streams (R8)
    foreach (VECS[n]) run_stream(VECS[n]);

    // R1: constant line after reset gives no strobe
    do_reset();
    line_in = 1'b0;
    begin
      int cnt = 0;
      repeat (40) begin
        @(negedge clk);
        if (sample_en) cnt++;
      end
      chk(cnt == 0, "R1", "strobes with idle line", cnt, 0);
      chk(sample_data == 1'b0, "R1", "sample_data with idle line", sample_data, 0);
    end

    // R3 latency, R4 width, R5 spacing, R6 hold, R7 reload
    line_in = 1'b1;
    for (int k = 1; k <= 45; k++) begin
      bit    exp_en;
      logic  exp_d;
      string req;
      @(negedge clk);
      exp_en = (k == 6 || k == 14 || k == 21 || k == 29 || k == 36 || k == 45);
      exp_d  = (k < 6) ? 1'b0 : ((k < 45) ? 1'b1 : 1'b0);
      if (k <= 6) req = "R3";
      else if (k == 7 || k == 15 || k == 22 || k == 30 || k == 37) req = "R4";
      else if (k >= 40) req = "R7";
      else req = "R5";
      chk(sample_en == exp_en, req, $sformatf("sample_en at cycle %0d", k), sample_en, exp_en);
      chk(sample_data == exp_d, "R6", $sformatf("sample_data at cycle %0d", k), sample_data, exp_d);
      if (k == 39) line_in = 1'b0;
    end

    // R9: reset during operation
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(sample_en == 1'b0, "R9", "sample_en under reset", sample_en, 0);
    chk(sample_data == 1'b0, "R9", "sample_data under reset", sample_data, 0);
    @(negedge clk);
    rst_n = 1'b1;
    begin
      int cnt = 0;
      repeat (40) begin
        @(negedge clk);
        if (sample_en) cnt++;
      end
      chk(cnt == 0, "R9", "strobes after mid-run reset", cnt, 0);
    end
    line_in = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk(sample_en == (k == 6), "R9", $sformatf("sample_en %0d after change", k),
          sample_en, (k == 6));
    end
    chk(sample_data == 1'b1, "R9", "sample_data after change", sample_data, 1);

    summary();
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    $display("FAIL watchdog: actual %0d expected %0d", WD_CYC, 0);
    n_chk++;
    summary();
  end

endmodule